// File: doc/BRIEF.md
# Stack frame save/restore sequencer

This block runs the function-entry and function-exit frame operations of a processor. On entry it pushes a chosen subset of the upper register group (r20 to r31) onto the stack, one word at a time. Each push lowers the stack pointer by one word and then writes at the new address. After the pushes it lowers the stack pointer further by a local frame size given in words. On exit it first releases the local frame. It then pops the chosen registers back with post-incrementing reads. If a return register is named, it finally raises a jump request whose target is that register's value.

The caller starts an operation with a one-cycle start pulse. With the pulse it supplies the operation select, the 12-bit register list, the 5-bit frame size, the return-register field and the current stack pointer. The sequencer reads register values through a combinational register-file read port. It writes restored values through a write port. Every memory access uses a word-wide request/ready handshake. When the operation ends, a one-cycle done pulse is raised. In that same cycle the final stack pointer is valid on `sp_o` and the jump request, if any, is presented.

Top module: `frame_seq`

## Requirements
- R1: List bit k (0 to 11) selects register r(20+k). Exactly one memory access is made per set bit, and no access is made for a clear bit.
- R2: On entry (op_i = 0), each store first lowers the stack pointer by 4. It then writes the selected register's value at the new stack pointer.
- R3: On entry, registers are stored in ascending register number, so a lower-numbered register ends up at a higher address.
- R4: On entry, after the stores the stack pointer is lowered by 4 times the frame size. The final `sp_o` equals sp_i minus 4 times (number of selected registers plus frame size).
- R5: On exit (op_i = 1), the stack pointer is first raised by 4 times the frame size. Each load then reads at the current stack pointer and raises it by 4 afterwards. The final `sp_o` equals sp_i plus 4 times (frame size plus number of selected registers).
- R6: On exit, the lowest address is loaded into the highest-numbered selected register, with descending register numbers after that. Each loaded word is written to the register file. Unselected registers are left unchanged.
- R7: A memory request stays asserted with a stable address and write data until ready is seen. Only then does the sequencer advance.
- R8: An empty register list makes no memory access. Only the frame adjustment is performed.
- R9: `done_o` is high for exactly one cycle per accepted start, in the cycle after the last stack-pointer update. `sp_o` holds the final stack pointer in that cycle.
- R10: `jump_o` is raised together with `done_o` only for an exit with a nonzero return-register field. In that case `jump_target_o` is that register's value after the restore. An entry or a zero field gives no jump.
- R11: A start pulse that arrives while an operation is running is ignored. It has no effect on the running operation's accesses or its final stack pointer.
- R12: After reset the sequencer is idle: no memory request, no register write, no done and no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| op_i | input | 1 | 0 = entry (save), 1 = exit (restore) |
| reg_list_i | input | 12 | Bit k selects r(20+k) |
| frame_words_i | input | 5 | Local frame size in words |
| ret_reg_i | input | 5 | Return register number for exit; 0 = none |
| sp_i | input | 32 | Stack pointer at start |
| sp_o | output | 32 | Working/final stack pointer, final when done_o is high |
| rf_addr_o | output | 5 | Register-file read/write index |
| rf_rdata_i | input | 32 | Combinational register-file read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory ready, completes the current request |
| done_o | output | 1 | One-cycle completion pulse |
| jump_o | output | 1 | Jump request, with done_o |
| jump_target_o | output | 32 | Jump target address |

## Verification
The bench uses the default parameters: 32-bit data, a 12-entry list and a 5-bit frame. This is small enough to reach every frame size from 0 to 31, every single-register list, the empty and full lists, and a spread of mixed lists. Each list goes through an entry and then an exit. The bench varies the memory latency between zero and two wait cycles and injects starts during busy cycles. For each operation it compares every access address and data word, the stack image, the restored registers and the final stack pointer against arithmetic expectations.

// File: rtl/frame_pkg.sv
package frame_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_ADJ, ST_FIN} seq_state_e;
  typedef enum logic [1:0] {STEP_DEC_WORD, STEP_INC_WORD, STEP_DEC_FRAME, STEP_INC_FRAME} step_e;
  typedef enum logic {OP_SAVE = 1'b0, OP_RESTORE = 1'b1} frame_op_e;
endpackage

// File: rtl/frame_pick.sv
module frame_pick #(
  parameter int W          = 12,
  parameter bit HIGH_FIRST = 1'b0,
  localparam int IW        = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  generate
    if (HIGH_FIRST) begin : g_high
      always_comb begin
        idx_o = '0;
        for (int k = 0; k < W; k++) if (vec_i[k]) idx_o = IW'(k);
      end
    end else begin : g_low
      always_comb begin
        idx_o = '0;
        for (int k = W - 1; k >= 0; k--) if (vec_i[k]) idx_o = IW'(k);
      end
    end
  endgenerate
endmodule

// File: rtl/frame_step.sv
module frame_step import frame_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 5
) (
  input  logic [DATA_W-1:0]  sp_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  step_e              kind_i,
  output logic [DATA_W-1:0]  sp_o
);
  localparam int SH = $clog2(DATA_W / 8);
  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(DATA_W / 8);

  logic [DATA_W-1:0] frame_bytes;
  assign frame_bytes = DATA_W'(frame_i) << SH;

  always_comb begin
    unique case (kind_i)
      STEP_DEC_WORD:  sp_o = sp_i - WORD_BYTES;
      STEP_INC_WORD:  sp_o = sp_i + WORD_BYTES;
      STEP_DEC_FRAME: sp_o = sp_i - frame_bytes;
      default:        sp_o = sp_i + frame_bytes;
    endcase
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq import frame_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int LIST_W   = 12,
  parameter int FRAME_W  = 5,
  parameter int RIDX_W   = 5,
  parameter int REG_BASE = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               op_i,
  input  logic [LIST_W-1:0]  reg_list_i,
  input  logic [FRAME_W-1:0] frame_words_i,
  input  logic [RIDX_W-1:0]  ret_reg_i,
  input  logic [DATA_W-1:0]  sp_i,
  output logic [DATA_W-1:0]  sp_o,
  output logic [RIDX_W-1:0]  rf_addr_o,
  input  logic [DATA_W-1:0]  rf_rdata_i,
  output logic               rf_we_o,
  output logic [DATA_W-1:0]  rf_wdata_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [DATA_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  input  logic               mem_ready_i,
  output logic               done_o,
  output logic               jump_o,
  output logic [DATA_W-1:0]  jump_target_o
);
  localparam int SEL_W = $clog2(LIST_W);

  seq_state_e         state_q;
  frame_op_e          op_q;
  logic [LIST_W-1:0]  pend_q;
  logic [FRAME_W-1:0] frame_q;
  logic [RIDX_W-1:0]  ret_q;
  logic [DATA_W-1:0]  sp_q;

  logic [SEL_W-1:0]   lo_idx, hi_idx, sel_idx;
  logic [LIST_W-1:0]  pend_clr;
  logic               last;
  logic               busy;
  step_e              step_kind;
  logic [DATA_W-1:0]  sp_next;

  // entry walks upward in register number, exit walks downward
  frame_pick #(.W(LIST_W), .HIGH_FIRST(1'b0)) u_pick_lo (.vec_i(pend_q), .idx_o(lo_idx));
  frame_pick #(.W(LIST_W), .HIGH_FIRST(1'b1)) u_pick_hi (.vec_i(pend_q), .idx_o(hi_idx));

  assign sel_idx  = (op_q == OP_RESTORE) ? hi_idx : lo_idx;
  assign pend_clr = pend_q & ~(LIST_W'(1) << sel_idx);
  assign last     = (pend_clr == '0);
  assign busy     = (state_q != ST_IDLE);

  always_comb begin
    if (state_q == ST_MEM) step_kind = (op_q == OP_RESTORE) ? STEP_INC_WORD : STEP_DEC_WORD;
    else                   step_kind = (op_q == OP_RESTORE) ? STEP_INC_FRAME : STEP_DEC_FRAME;
  end

  frame_step #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_step (
    .sp_i(sp_q), .frame_i(frame_q), .kind_i(step_kind), .sp_o(sp_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_SAVE;
      pend_q  <= '0;
      frame_q <= '0;
      ret_q   <= '0;
      sp_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          op_q    <= frame_op_e'(op_i);
          pend_q  <= reg_list_i;
          frame_q <= frame_words_i;
          ret_q   <= ret_reg_i;
          sp_q    <= sp_i;
          if (op_i || reg_list_i == '0) state_q <= ST_ADJ;
          else                          state_q <= ST_MEM;
        end
        ST_MEM: if (mem_ready_i) begin
          sp_q   <= sp_next;
          pend_q <= pend_clr;
          if (last) state_q <= (op_q == OP_RESTORE) ? ST_FIN : ST_ADJ;
        end
        ST_ADJ: begin
          sp_q    <= sp_next;
          state_q <= (op_q == OP_RESTORE && pend_q != '0) ? ST_MEM : ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sp_o          = sp_q;
  assign rf_addr_o     = (state_q == ST_FIN) ? ret_q : RIDX_W'(REG_BASE) + RIDX_W'(sel_idx);
  assign rf_we_o       = (state_q == ST_MEM) && (op_q == OP_RESTORE) && mem_ready_i;
  assign rf_wdata_o    = mem_rdata_i;
  assign mem_req_o     = (state_q == ST_MEM);
  assign mem_we_o      = (state_q == ST_MEM) && (op_q == OP_SAVE);
  assign mem_addr_o    = (op_q == OP_SAVE) ? sp_next : sp_q;
  assign mem_wdata_o   = rf_rdata_i;
  assign done_o        = (state_q == ST_FIN);
  assign jump_o        = (state_q == ST_FIN) && (op_q == OP_RESTORE) && (ret_q != '0);
  assign jump_target_o = rf_rdata_i;
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ready_i,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] sp_o,
  input logic              rf_we_o,
  input logic              done_o,
  input logic              jump_o
);
  localparam logic [DATA_W-1:0] WB = DATA_W'(DATA_W / 8);

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_store_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i && mem_we_o |=> sp_o == $past(sp_o) - WB);

  p_load_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i && !mem_we_o |=> sp_o == $past(sp_o) + WB);

  p_rf_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> mem_req_o && mem_ready_i && !mem_we_o);

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_jump_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> done_o);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mem_req_o && !rf_we_o);
endmodule

bind frame_seq frame_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .sp_o(sp_o),
  .rf_we_o(rf_we_o), .done_o(done_o), .jump_o(jump_o)
);

// File: tb/sim_frame_seq.sv
module sim_frame_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, op_i = 1'b0;
  logic [11:0] reg_list_i = '0;
  logic [4:0]  frame_words_i = '0, ret_reg_i = '0;
  logic [31:0] sp_i = '0;
  logic [31:0] sp_o, rf_rdata_i, rf_wdata_o, mem_addr_o, mem_wdata_o, mem_rdata_i, jump_target_o;
  logic [4:0]  rf_addr_o;
  logic        rf_we_o, mem_req_o, mem_we_o, mem_ready_i, done_o, jump_o;

  logic [31:0] regs [32];
  logic [31:0] mem  [256];
  int          lat_cfg = 0, wait_cnt = 0;
  int          total = 0, bad = 0;

  logic        mon_op;
  logic [11:0] mon_list;
  logic [31:0] mon_sp;
  int          acc_cnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .op_i(op_i), .reg_list_i(reg_list_i),
    .frame_words_i(frame_words_i), .ret_reg_i(ret_reg_i), .sp_i(sp_i), .sp_o(sp_o),
    .rf_addr_o(rf_addr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i), .done_o(done_o), .jump_o(jump_o),
    .jump_target_o(jump_target_o)
  );

  assign rf_rdata_i  = regs[rf_addr_o];
  assign mem_rdata_i = mem[mem_addr_o[9:2]];
  assign mem_ready_i = mem_req_o && (wait_cnt >= lat_cfg);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int pop12(input logic [11:0] v);
    int n = 0;
    for (int k = 0; k < 12; k++) n += int'(v[k]);
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= 0;
    else if (mem_req_o && !mem_ready_i) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
  end

  // memory, register file and access-order monitor
  always @(posedge clk) begin
    if (rst_n && mem_req_o && mem_ready_i) begin
      int k;
      k = 0;
      acc_cnt++;
      if (!mon_op) begin
        for (int b = 11; b >= 0; b--) if (mon_list[b]) k = b;
        mon_sp = mon_sp - 32'd4;
        chk(mem_we_o == 1'b1, "R2 store kind", 32'(mem_we_o), 32'd1);
        chk(mem_addr_o == mon_sp, "R2 store addr", mem_addr_o, mon_sp);
        chk(mem_wdata_o == regs[20 + k], "R3 store order/data", mem_wdata_o, regs[20 + k]);
        mem[mem_addr_o[9:2]] <= mem_wdata_o;
      end else begin
        for (int b = 0; b < 12; b++) if (mon_list[b]) k = b;
        chk(mem_we_o == 1'b0, "R5 load kind", 32'(mem_we_o), 32'd0);
        chk(mem_addr_o == mon_sp, "R5 load addr", mem_addr_o, mon_sp);
        chk(rf_addr_o == 5'(20 + k), "R6 restore order", 32'(rf_addr_o), 32'(20 + k));
        mon_sp = mon_sp + 32'd4;
      end
      mon_list[k] = 1'b0;
    end
    if (rf_we_o) regs[rf_addr_o] <= rf_wdata_o;
  end

  logic [31:0] res_sp, res_tgt;
  logic        res_jump;

  task automatic run_op(input logic op, input logic [11:0] list, input logic [4:0] frame,
                        input logic [4:0] ret, input logic [31:0] sp, input bit poke);
    int cyc;
    @(negedge clk);
    mon_op = op; mon_list = list; acc_cnt = 0;
    mon_sp = op ? sp + 32'(frame) * 4 : sp;
    start_i = 1'b1; op_i = op; reg_list_i = list; frame_words_i = frame; ret_reg_i = ret; sp_i = sp;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      start_i = 1'b1; op_i = ~op; reg_list_i = ~list; frame_words_i = ~frame; sp_i = 32'h40;
      @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    chk(done_o == 1'b1, "R9 done seen", 32'(done_o), 32'd1);
    res_sp = sp_o; res_jump = jump_o; res_tgt = jump_target_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done single pulse", 32'(done_o), 32'd0);
    chk(acc_cnt == pop12(list), "R1 R8 access count", 32'(acc_cnt), 32'(pop12(list)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] orig [12];
    logic [31:0] sp0, sp1, exp_v, exp_t;
    logic [11:0] list;
    logic [4:0]  frame, ret;
    int          n, pos;
    mon_op = 1'b0; mon_list = '0; mon_sp = '0; acc_cnt = 0;
    for (int r = 0; r < 32; r++) regs[r] = 32'(r);
    for (int j = 0; j < 256; j++) mem[j] = 32'hDEAD_0000 | 32'(j);
    #(CLK_PERIOD * 2 + 1);
    chk(!mem_req_o && !rf_we_o, "R12 reset idle mem/rf", {30'd0, mem_req_o, rf_we_o}, 32'd0);
    chk(!done_o && !jump_o, "R12 reset idle done/jump", {30'd0, done_o, jump_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 64; i++) begin
      if (i < 12)       list = 12'(1) << i;
      else if (i == 12) list = 12'h000;
      else if (i == 13) list = 12'hFFF;
      else              list = 12'((i * 1103 + 77) % 4096);
      frame   = 5'(i % 32);
      ret     = (i % 4 == 0) ? 5'd0 : (i % 4 == 1) ? 5'd5 : 5'(20 + (i % 12));
      lat_cfg = i % 3;
      n       = pop12(list);
      for (int r = 0; r < 32; r++) regs[r] = 32'hA500_0000 | (32'(r) << 8) | 32'(i);
      for (int k = 0; k < 12; k++) orig[k] = regs[20 + k];
      for (int j = 0; j < 256; j++) mem[j] = 32'hDEAD_0000 | 32'(j);
      sp0 = 32'h0000_0380;

      // entry
      run_op(1'b0, list, frame, ret, sp0, (i % 5 == 0));
      exp_v = sp0 - 32'(n + int'(frame)) * 4;
      chk(res_sp == exp_v, (i % 5 == 0) ? "R11 R4 entry sp with busy start" : "R4 entry sp",
          res_sp, exp_v);
      chk(res_jump == 1'b0, "R10 no jump on entry", 32'(res_jump), 32'd0);
      pos = 0;
      for (int k = 0; k < 12; k++) if (list[k]) begin
        pos++;
        chk(mem[(sp0 - 32'(pos) * 4) >> 2 & 32'hFF] == orig[k], "R3 stack image",
            mem[(sp0 - 32'(pos) * 4) >> 2 & 32'hFF], orig[k]);
      end
      if (n == 0) chk(mem[(sp0 - 32'd4) >> 2 & 32'hFF] == (32'hDEAD_0000 | ((sp0 - 32'd4) >> 2 & 32'hFF)),
                      "R8 empty list leaves memory", mem[(sp0 - 32'd4) >> 2 & 32'hFF],
                      32'hDEAD_0000 | ((sp0 - 32'd4) >> 2 & 32'hFF));

      // scramble, then exit
      for (int k = 0; k < 12; k++) regs[20 + k] = ~orig[k];
      sp1 = res_sp;
      run_op(1'b1, list, frame, ret, sp1, (i % 7 == 3));
      chk(res_sp == sp0, (i % 7 == 3) ? "R11 R5 exit sp with busy start" : "R5 exit sp", res_sp, sp0);
      for (int k = 0; k < 12; k++) begin
        exp_v = list[k] ? orig[k] : ~orig[k];
        chk(regs[20 + k] == exp_v, "R6 register restore", regs[20 + k], exp_v);
      end
      chk(res_jump == (ret != 5'd0), "R10 jump request", 32'(res_jump), 32'(ret != 5'd0));
      if (ret != 5'd0) begin
        if (ret >= 5'd20) exp_t = list[ret - 5'd20] ? orig[ret - 5'd20] : ~orig[ret - 5'd20];
        else              exp_t = 32'hA500_0000 | (32'(ret) << 8) | 32'(i);
        chk(res_tgt == exp_t, "R10 jump target", res_tgt, exp_t);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule